// File: doc/BRIEF.md
# Dual-Width Move / XOR / Arithmetic-Shift Execution Unit

This unit is one execution slice of a 64-bit register machine. Each cycle it may accept one operation and produce its result one clock later. It supports four operations: exclusive-OR, plain move, sign-extending move and arithmetic right shift. A class bit selects whether the operation runs on the full 64-bit datapath or on the low 32 bits.

The operation is chosen by a 4-bit code taken from the upper nibble of the opcode byte. A 16-bit offset field selects the width of a sign-extending move. A select bit chooses whether the second operand comes from the register source or from a 32-bit immediate. In 64-bit mode the immediate is sign-widened. In 32-bit mode it is used as a 32-bit value.

An encoding the unit does not support does not fault the machine. It raises a flag and passes the destination operand through unchanged.

Top module: `sxalu_top`

## Requirements
- R1: Code 0xA with offset 0 returns the destination XOR the second operand.
- R2: Code 0xB with offset 0 returns the second operand unchanged (a plain move).
- R3: In 64-bit mode, code 0xB with offset 8, 16 or 32 takes the low 8, 16 or 32 bits of the second operand and fills every higher bit of the 64-bit result with that field's top bit.
- R4: In 32-bit mode, code 0xB with offset 8 or 16 sign-widens the field to 32 bits and zeroes result bits 63:32. Offset 32 in 32-bit mode is an illegal encoding.
- R5: In 64-bit mode, code 0xC shifts the destination right by (second operand AND 0x3F). Vacated bits are copied from destination bit 63.
- R6: In 32-bit mode, code 0xC shifts destination bits 31:0 right by (second operand AND 0x1F). Vacated bits are copied from destination bit 31, and bit 63 is ignored.
- R7: In 32-bit mode, every legal operation returns zero in result bits 63:32.
- R8: With the immediate selected, the 32-bit immediate is sign-extended to 64 bits in 64-bit mode. In 32-bit mode its upper 32 bits are zero.
- R9: Any offset other than 0/8/16/32 with code 0xB, a non-zero offset with codes 0xA or 0xC, or any other code raises the illegal flag. In that case the result equals the full 64-bit destination operand.
- R10: The result, the illegal flag and the valid flag appear on the clock edge after an input strobe. Valid is low after a cycle without a strobe. A synchronous active-low reset clears valid, even when a strobe is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe: capture this operation |
| op_code | input | 4 | Operation code (upper opcode nibble) |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| off_fld | input | 16 | Offset field; selects sign-extension width |
| use_imm | input | 1 | 1 = second operand is the immediate |
| dst_val | input | 64 | Destination operand |
| src_val | input | 64 | Register source operand |
| imm_val | input | 32 | Immediate operand |
| res_val | output | 64 | Registered result |
| res_ok | output | 1 | Result valid |
| res_bad | output | 1 | Illegal-encoding flag |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a 32-bit immediate and a 16-bit offset field. This brings the full 6-bit shift range and both class widths within reach. It also covers the case where the 32-bit field sits exactly at the half-word boundary, which is the case that separates the legal 64-bit widening from the illegal 32-bit one. The vectors place different values in destination bits 63 and 31, so a shift that takes its fill from the wrong bit is exposed. Immediates with the top bit set tell sign-widening apart from zero-widening.

// File: rtl/sxalu_pkg.sv
// Shared opcode constants and internal operation kinds for the
// move / XOR / arithmetic-shift execution unit.
package sxalu_pkg;
    localparam logic [3:0] OPC_XOR  = 4'hA;
    localparam logic [3:0] OPC_MOV  = 4'hB;
    localparam logic [3:0] OPC_ASHR = 4'hC;

    typedef enum logic [1:0] {K_XOR, K_MOV, K_ASHR, K_NONE} kind_e;
    // sign-extension field width for moves
    typedef enum logic [1:0] {SX_NONE, SX_B, SX_H, SX_W} sxw_e;
endpackage

// File: rtl/sxalu_srcsel.sv
// Second-operand select: register source or widened immediate.
// Assumes XLEN > IMMW. 64-bit mode sign-widens the immediate;
// 32-bit mode zero-fills above it.
module sxalu_srcsel #(
    parameter int XLEN = 64,
    parameter int IMMW = 32
) (
    input  logic            use_imm,
    input  logic            wide,
    input  logic [XLEN-1:0] src_val,
    input  logic [IMMW-1:0] imm_val,
    output logic [XLEN-1:0] opnd
);
    localparam int PADW = XLEN - IMMW;

    // choose source and widen the immediate per mode
    always_comb begin
        if (!use_imm)
            opnd = src_val;
        else if (wide)
            opnd = {{PADW{imm_val[IMMW-1]}}, imm_val};
        else
            opnd = {{PADW{1'b0}}, imm_val};
    end
endmodule

// File: rtl/sxalu_decode.sv
// Decodes opcode nibble, class bit and offset field into an operation
// kind and a sign-extension width; flags unsupported encodings.
module sxalu_decode
    import sxalu_pkg::*;
#(
    parameter int OFFW = 16
) (
    input  logic [3:0]      op_code,
    input  logic            wide,
    input  logic [OFFW-1:0] off_fld,
    output kind_e           kind,
    output sxw_e            sxw,
    output logic            bad
);
    // classify the encoding
    always_comb begin
        kind = K_NONE;
        sxw  = SX_NONE;
        bad  = 1'b0;
        unique case (op_code)
            OPC_XOR: begin
                if (off_fld == '0) kind = K_XOR;
                else               bad  = 1'b1;
            end
            OPC_ASHR: begin
                if (off_fld == '0) kind = K_ASHR;
                else               bad  = 1'b1;
            end
            OPC_MOV: begin
                if (off_fld == OFFW'(0)) begin
                    kind = K_MOV;
                end else if (off_fld == OFFW'(8)) begin
                    kind = K_MOV; sxw = SX_B;
                end else if (off_fld == OFFW'(16)) begin
                    kind = K_MOV; sxw = SX_H;
                end else if (off_fld == OFFW'(32) && wide) begin
                    kind = K_MOV; sxw = SX_W;
                end else begin
                    bad = 1'b1;
                end
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/sxalu_exec.sv
// Combinational datapath: XOR, move, sign-extending move, arithmetic
// right shift, with 32-bit mode clearing the upper half. Assumes
// XLEN is a power of two and at least 64.
module sxalu_exec
    import sxalu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  kind_e           kind,
    input  sxw_e            sxw,
    input  logic            wide,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] opnd,
    output logic [XLEN-1:0] res
);
    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    logic [XLEN-1:0] sx_b, sx_h, sx_w, mov_v, shr_full, raw;
    logic [HALF-1:0] shr_half;

    // sign-widened copies of the operand's low fields
    always_comb begin
        sx_b = {{(XLEN-8){opnd[7]}}, opnd[7:0]};
        sx_h = {{(XLEN-16){opnd[15]}}, opnd[15:0]};
        sx_w = {{(XLEN-32){opnd[31]}}, opnd[31:0]};
    end

    // pick the move variant
    always_comb begin
        unique case (sxw)
            SX_B:    mov_v = sx_b;
            SX_H:    mov_v = sx_h;
            SX_W:    mov_v = sx_w;
            default: mov_v = opnd;
        endcase
    end

    // arithmetic shifts for both widths with their own amount masks
    always_comb begin
        shr_full = $signed(dst_val) >>> opnd[SHW-1:0];
        shr_half = $signed(dst_val[HALF-1:0]) >>> opnd[SHW-2:0];
    end

    // select the operation, then apply the half-width clear
    always_comb begin
        unique case (kind)
            K_XOR:   raw = dst_val ^ opnd;
            K_MOV:   raw = mov_v;
            K_ASHR:  raw = wide ? shr_full : {{HALF{1'b0}}, shr_half};
            default: raw = dst_val;
        endcase
        res = wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    end
endmodule

// File: rtl/sxalu_top.sv
// Single-issue execution unit top: operand select, decode, datapath,
// one output register stage. Illegal encodings return the destination.
// Synchronous active-low reset.
module sxalu_top
    import sxalu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 32,
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op_code,
    input  logic            wide,
    input  logic [OFFW-1:0] off_fld,
    input  logic            use_imm,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [IMMW-1:0] imm_val,
    output logic [XLEN-1:0] res_val,
    output logic            res_ok,
    output logic            res_bad
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] opnd, core_res, next_res;
    kind_e           kind;
    sxw_e            sxw;
    logic            bad_c;

    sxalu_srcsel #(.XLEN(XLEN), .IMMW(IMMW)) u_src (
        .use_imm(use_imm), .wide(wide), .src_val(src_val),
        .imm_val(imm_val), .opnd(opnd)
    );

    sxalu_decode #(.OFFW(OFFW)) u_dec (
        .op_code(op_code), .wide(wide), .off_fld(off_fld),
        .kind(kind), .sxw(sxw), .bad(bad_c)
    );

    sxalu_exec #(.XLEN(XLEN)) u_exe (
        .kind(kind), .sxw(sxw), .wide(wide), .dst_val(dst_val),
        .opnd(opnd), .res(core_res)
    );

    // illegal encodings pass the destination through untouched
    always_comb next_res = bad_c ? dst_val : core_res;

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_ok  <= 1'b0;
            res_bad <= 1'b0;
            res_val <= '0;
        end else begin
            res_ok <= in_valid;
            if (in_valid) begin
                res_val <= next_res;
                res_bad <= bad_c;
            end
        end
    end

    p_strobe_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_ok);
    p_idle_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_ok);
    p_half_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide && !bad_c) |=> (res_val[XLEN-1:HALF] == '0));
    p_illegal_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_c) |=> (res_bad && res_val == $past(dst_val)));
    p_narrow_w32_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide && op_code == OPC_MOV && off_fld == OFFW'(32))
        |=> res_bad);
    p_xor_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && !use_imm && op_code == OPC_XOR && off_fld == '0)
        |=> (res_val == ($past(dst_val) ^ $past(src_val))));
endmodule

// File: tb/sim_sxalu_top.sv
`timescale 1ns/1ps
module sim_sxalu_top;
    typedef struct packed {
        logic [3:0]  op;
        logic        wd;
        logic [15:0] off;
        logic        im;
        logic [63:0] dst;
        logic [63:0] src;
        logic [31:0] imm;
        logic [63:0] exp;
        logic        xbad;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        // R1 xor 64
        '{4'hA,1'b1,16'd0,1'b0,64'hFF00_FF00_1234_5678,64'h0F0F_0F0F_FFFF_0000,32'h0,64'hF00F_F00F_EDCB_5678,1'b0,4'd1},
        // R7 xor 32
        '{4'hA,1'b0,16'd0,1'b0,64'hFF00_FF00_1234_5678,64'h0F0F_0F0F_FFFF_0000,32'h0,64'h0000_0000_EDCB_5678,1'b0,4'd7},
        // R2 mov 64
        '{4'hB,1'b1,16'd0,1'b0,64'h0,64'h8123_4567_89AB_CDEF,32'h0,64'h8123_4567_89AB_CDEF,1'b0,4'd2},
        // R7 mov 32
        '{4'hB,1'b0,16'd0,1'b0,64'h0,64'h8123_4567_89AB_CDEF,32'h0,64'h0000_0000_89AB_CDEF,1'b0,4'd7},
        // R3 sx byte 64
        '{4'hB,1'b1,16'd8,1'b0,64'h0,64'h8123_4567_89AB_CDEF,32'h0,64'hFFFF_FFFF_FFFF_FFEF,1'b0,4'd3},
        // R3 sx half 64 positive
        '{4'hB,1'b1,16'd16,1'b0,64'h0,64'hDEAD_BEEF_1234_7ABC,32'h0,64'h0000_0000_0000_7ABC,1'b0,4'd3},
        // R3 sx word 64
        '{4'hB,1'b1,16'd32,1'b0,64'h0,64'h0000_0000_8000_0001,32'h0,64'hFFFF_FFFF_8000_0001,1'b0,4'd3},
        // R4 sx byte 32
        '{4'hB,1'b0,16'd8,1'b0,64'h0,64'hFFFF_FFFF_FFFF_FF80,32'h0,64'h0000_0000_FFFF_FF80,1'b0,4'd4},
        // R4 sx half 32
        '{4'hB,1'b0,16'd16,1'b0,64'h0,64'h1111_1111_2222_9000,32'h0,64'h0000_0000_FFFF_9000,1'b0,4'd4},
        // R4 sx word in 32-bit mode is illegal
        '{4'hB,1'b0,16'd32,1'b0,64'hCAFE_F00D_0BAD_BEEF,64'h0000_0000_8000_0001,32'h0,64'hCAFE_F00D_0BAD_BEEF,1'b1,4'd4},
        // R5 ashr 64
        '{4'hC,1'b1,16'd0,1'b0,64'h8000_0000_0000_0000,64'd4,32'h0,64'hF800_0000_0000_0000,1'b0,4'd5},
        // R5 ashr 64 masked amount 0x44 -> 4
        '{4'hC,1'b1,16'd0,1'b0,64'h4000_0000_0000_0010,64'h44,32'h0,64'h0400_0000_0000_0001,1'b0,4'd5},
        // R6 ashr 32 masked 0x21 -> 1, fill from bit 31
        '{4'hC,1'b0,16'd0,1'b0,64'h0000_0000_8000_0000,64'h21,32'h0,64'h0000_0000_C000_0000,1'b0,4'd6},
        // R6 ashr 32 ignores bit 63
        '{4'hC,1'b0,16'd0,1'b0,64'hFFFF_FFFF_7000_0000,64'd4,32'h0,64'h0000_0000_0700_0000,1'b0,4'd6},
        // R8 xor imm 64
        '{4'hA,1'b1,16'd0,1'b1,64'h0,64'h0,32'h8000_0001,64'hFFFF_FFFF_8000_0001,1'b0,4'd8},
        // R8 xor imm 32
        '{4'hA,1'b0,16'd0,1'b1,64'h1,64'h0,32'h8000_0001,64'h0000_0000_8000_0000,1'b0,4'd8},
        // R8 mov imm 64 positive
        '{4'hB,1'b1,16'd0,1'b1,64'h0,64'hFFFF_FFFF_FFFF_FFFF,32'h7FFF_FFFF,64'h0000_0000_7FFF_FFFF,1'b0,4'd8},
        // R9 mov bad offset
        '{4'hB,1'b1,16'd4,1'b0,64'h0123_4567_89AB_CDEF,64'h5,32'h0,64'h0123_4567_89AB_CDEF,1'b1,4'd9},
        // R9 xor non-zero offset
        '{4'hA,1'b0,16'd1,1'b0,64'hAAAA_BBBB_CCCC_DDDD,64'h5,32'h0,64'hAAAA_BBBB_CCCC_DDDD,1'b1,4'd9},
        // R9 unknown code
        '{4'h3,1'b1,16'd0,1'b0,64'h1357_9BDF_2468_ACE0,64'h5,32'h0,64'h1357_9BDF_2468_ACE0,1'b1,4'd9},
        // R8 ashr 64 by imm 0xFFFFFFC1 -> amount 1
        '{4'hC,1'b1,16'd0,1'b1,64'h8000_0000_0000_0002,64'h0,32'hFFFF_FFC1,64'hC000_0000_0000_0001,1'b0,4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n, in_valid, wide, use_imm;
    logic [3:0]  op_code;
    logic [15:0] off_fld;
    logic [63:0] dst_val, src_val, res_val;
    logic [31:0] imm_val;
    logic        res_ok, res_bad;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sxalu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .wide(wide), .off_fld(off_fld), .use_imm(use_imm), .dst_val(dst_val),
        .src_val(src_val), .imm_val(imm_val), .res_val(res_val),
        .res_ok(res_ok), .res_bad(res_bad)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; wide = 1'b0; use_imm = 1'b0;
        op_code = '0; off_fld = '0; dst_val = '0; src_val = '0; imm_val = '0;
        repeat (3) @(negedge clk);
        check("R10 reset valid", {63'b0, res_ok}, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_code = VEC[i].op; wide = VEC[i].wd; off_fld = VEC[i].off;
            use_imm = VEC[i].im; dst_val = VEC[i].dst; src_val = VEC[i].src;
            imm_val = VEC[i].imm; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vec %0d result", VEC[i].req, i), res_val, VEC[i].exp);
            check($sformatf("R%0d vec %0d illegal", VEC[i].req, i), {63'b0, res_bad}, {63'b0, VEC[i].xbad});
            check("R10 valid after strobe", {63'b0, res_ok}, 64'd1);
            @(negedge clk);
            check("R10 valid low when idle", {63'b0, res_ok}, 64'd0);
        end
        // R10: reset wins over a concurrent strobe
        op_code = 4'hA; wide = 1'b1; off_fld = '0; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset over strobe", {63'b0, res_ok}, 64'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule